// File: doc/BRIEF.md
# Register File with Two Read Ports, One Write Port and Write-Through Bypass

This block holds the general-purpose registers of a scalar pipeline. Instruction decode presents two source indexes and gets both operand values back in the same cycle through combinational read paths. Writeback commits one destination value per cycle through a synchronous write port.

Decode and writeback work in the same cycle, so decode can ask for the very register that writeback is updating. The design does not rely on a storage cell that can be read and written at once. When such a collision occurs, the incoming write value is routed straight to the matching read port. Decode therefore sees the new value without waiting a cycle.

Index zero is a constant-zero register. Writes to it are dropped, and it never takes part in bypassing. The entry count and the data width are parameters, with defaults of 32 entries and 32 bits. Forwarding from later pipeline stages is handled elsewhere.

Top module: `rf2r1w_bypass`

## Requirements
- R1: A value written to a nonzero index at a rising clock edge is returned by either read port addressing that index in every later cycle, until that index is written again or reset is applied.
- R2: When `wrEn` is low at a rising edge, no entry changes. When `wrEn` is low, no read port returns `wrData` because of an index match.
- R3: The two read ports are independent and combinational. Each port returns the entry named by its own index in the same cycle, whatever the other port addresses.
- R4: When `wrEn` is high and `wrIdx` is nonzero and equal to a read index, that read port returns `wrData` in that same cycle, not the stored value.
- R5: A read of index 0 always returns all zeros.
- R6: A write to index 0 is discarded. Reading index 0 in the same cycle as that write returns zero, and no other entry changes.
- R7: While `rstN` is low, entries 1 to 31 are cleared to zero. The reset is asynchronous and active low.
- R8: When both read ports address the index being written, both ports return `wrData` in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request from writeback |
| wrIdx | input | 5 | Destination index |
| wrData | input | 32 | Value to write |
| rdIdxA | input | 5 | First source index |
| rdDataA | output | 32 | First source value |
| rdIdxB | input | 5 | Second source index |
| rdDataB | output | 32 | Second source value |

## Verification
After a reset, the bench reads every index to confirm the cleared state. It then fills all entries with distinct patterns and reads them back with the two ports on different indexes, which separates the two read paths and catches wrong decoding.

Same-cycle collisions are driven on port A alone, on port B alone and on both ports together. Each check reads the entry again on the next cycle, to tell a bypass apart from a stored write.

A matching index with the write enable low shows that bypass is gated by the enable. A write to index 0 confirms that the zero register neither stores nor forwards. A second reset in the middle of the run confirms the clear after the entries have held data.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // number of read ports served by the file
  localparam int NUM_RD = 2;

  // strobes handed from control to datapath
  typedef struct packed {
    logic              wrCommit;   // write lands in storage this edge
    logic [NUM_RD-1:0] rdZero;     // port addresses the constant-zero index
    logic [NUM_RD-1:0] rdBypass;   // port takes the incoming write value
  } rfCtrl_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rdIdx,
  output rfCtrl_t                       ctrl
);
  logic wrNonZero;

  assign wrNonZero = (wrIdx != '0);

  always_comb begin
    ctrl = '0;
    ctrl.wrCommit = wrEn && wrNonZero;
    for (int p = 0; p < NUM_RD; p++) begin
      ctrl.rdZero[p]   = (rdIdx[p] == '0);
      ctrl.rdBypass[p] = wrEn && wrNonZero && (rdIdx[p] == wrIdx);
    end
  end

  // index 0 never commits (R6)
  p_no_commit_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrIdx == '0) |-> !ctrl.wrCommit);

  // a disabled write never forwards (R2)
  p_no_bypass_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (ctrl.rdBypass == '0));

  genvar g;
  generate
    for (g = 0; g < NUM_RD; g++) begin : g_chk
      // zero select and bypass select never coincide (R5)
      p_sel_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0({ctrl.rdZero[g], ctrl.rdBypass[g]}));
    end
  endgenerate
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rfCtrl_t                       ctrl,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rdIdx,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] cellQ [NUM_REGS];

  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_cell
      if (i == 0) begin : g_zero
        assign cellQ[i] = '0;
      end else begin : g_store
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)
            cellQ[i] <= '0;
          else if (ctrl.wrCommit && (wrIdx == IDX_W'(i)))
            cellQ[i] <= wrData;
        end
      end
    end
  endgenerate

  genvar p;
  generate
    for (p = 0; p < NUM_RD; p++) begin : g_rd
      always_comb begin
        if (ctrl.rdZero[p])
          rdData[p] = '0;
        else if (ctrl.rdBypass[p])
          rdData[p] = wrData;
        else
          rdData[p] = cellQ[rdIdx[p]];
      end

      // index 0 reads zero (R5)
      p_zero_read_r5: assert property (@(posedge clk) disable iff (!rstN)
        (rdIdx[p] == '0) |-> (rdData[p] == '0));

      // a committed write is visible on the next cycle (R1)
      p_write_lands_r1: assert property (@(posedge clk) disable iff (!rstN)
        ctrl.wrCommit |=>
          (!(rdIdx[p] == $past(wrIdx) && !ctrl.rdBypass[p]) ||
           rdData[p] == $past(wrData)));

      // with no write, a steady index gives a steady value (R2)
      p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
        !ctrl.wrCommit |=>
          (!($stable(rdIdx[p]) && !ctrl.rdBypass[p]) || $stable(rdData[p])));
    end
  endgenerate
endmodule

// File: rtl/rf2r1w_bypass.sv
module rf2r1w_bypass
  import rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB
);
  rfCtrl_t                       ctrl;
  logic [NUM_RD-1:0][IDX_W-1:0]  rdIdx;
  logic [NUM_RD-1:0][DATA_W-1:0] rdData;

  assign rdIdx[0] = rdIdxA;
  assign rdIdx[1] = rdIdxB;
  assign rdDataA  = rdData[0];
  assign rdDataB  = rdData[1];

  rf_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrIdx (wrIdx),
    .rdIdx (rdIdx),
    .ctrl  (ctrl)
  );

  rf_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );

  // matching enabled write forwards on both ports (R4, R8)
  p_bypass_both_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != '0 && rdIdxA == wrIdx && rdIdxB == wrIdx) |->
      (rdDataA == wrData && rdDataB == wrData));
endmodule

// File: tb/rf2r1w_bypass_tb_top.sv
module rf2r1w_bypass_tb_top;
  localparam int DW = 32;
  localparam int NR = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [IW-1:0] wrIdx = '0;
  logic [DW-1:0] wrData = '0;
  logic [IW-1:0] rdIdxA = '0;
  logic [IW-1:0] rdIdxB = '0;
  logic [DW-1:0] rdDataA;
  logic [DW-1:0] rdDataB;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [DW-1:0] expA;
    logic [DW-1:0] expB;
    string         req;
  } item_t;

  item_t         sbQ[$];
  logic [DW-1:0] model [NR];
  event          sampleEv;

  always #2 clk = ~clk;

  rf2r1w_bypass dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB)
  );

  function automatic logic [DW-1:0] expect_rd(logic [IW-1:0] idx, logic we,
                                             logic [IW-1:0] wi, logic [DW-1:0] wd);
    if (idx == '0) return '0;
    if (rstN && we && wi == idx) return wd;
    return model[idx];
  endfunction

  // driver: one cycle of stimulus, expected results pushed to the queue
  task automatic step(logic we, logic [IW-1:0] wi, logic [DW-1:0] wd,
                      logic [IW-1:0] ra, logic [IW-1:0] rb, string req);
    item_t it;
    @(negedge clk);
    wrEn = we; wrIdx = wi; wrData = wd; rdIdxA = ra; rdIdxB = rb;
    it.expA = expect_rd(ra, we, wi, wd);
    it.expB = expect_rd(rb, we, wi, wd);
    it.req  = req;
    sbQ.push_back(it);
    -> sampleEv;
    if (rstN && we && wi != '0) model[wi] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    for (int k = 0; k < NR; k++) model[k] = '0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // monitor: samples between the driving edge and the active edge
  initial begin
    forever begin
      @(sampleEv);
      #1;
      if (sbQ.size() != 0) begin
        item_t it;
        it = sbQ.pop_front();
        checks++;
        if (rdDataA !== it.expA) begin
          errors++;
          $display("FAIL %s port A: actual=%h expected=%h", it.req, rdDataA, it.expA);
        end
        checks++;
        if (rdDataB !== it.expB) begin
          errors++;
          $display("FAIL %s port B: actual=%h expected=%h", it.req, rdDataB, it.expB);
        end
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NR; k++) model[k] = '0;
    do_reset();
    // R7: cleared state
    for (int k = 0; k < NR; k += 2) step(1'b0, '0, '0, IW'(k), IW'(k + 1), "R7");
    // R1: fill every entry, reading unrelated indexes
    for (int k = 1; k < NR; k++)
      step(1'b1, IW'(k), 32'hA5000000 ^ (32'(k) * 32'h01010101), IW'(NR - k), IW'(k - 1), "R1");
    // R3: independent readback, ports on different indexes
    for (int k = 0; k < NR; k++) step(1'b0, '0, '0, IW'(k), IW'(NR - 1 - k), "R3");
    // R2: matching index but write disabled, then verify nothing stored
    step(1'b0, 5'd7, 32'hDEADBEEF, 5'd7, 5'd7, "R2");
    step(1'b0, 5'd0, 32'h0, 5'd7, 5'd8, "R2");
    // R4: bypass on port A only, then port B only, then stored
    step(1'b1, 5'd9, 32'h11112222, 5'd9, 5'd10, "R4");
    step(1'b1, 5'd10, 32'h33334444, 5'd9, 5'd10, "R4");
    step(1'b0, 5'd0, 32'h0, 5'd10, 5'd9, "R1");
    // R8: both ports bypassed
    step(1'b1, 5'd31, 32'hCAFEF00D, 5'd31, 5'd31, "R8");
    step(1'b1, 5'd1, 32'h0BADC0DE, 5'd1, 5'd1, "R8");
    step(1'b0, 5'd0, 32'h0, 5'd31, 5'd1, "R1");
    // R5/R6: write to index 0 neither stores nor forwards
    step(1'b1, 5'd0, 32'hFFFFFFFF, 5'd0, 5'd0, "R6");
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd31, "R5");
    // back-to-back writes to the same index
    step(1'b1, 5'd12, 32'h00000001, 5'd12, 5'd13, "R4");
    step(1'b1, 5'd12, 32'h00000002, 5'd12, 5'd12, "R4");
    step(1'b0, 5'd0, 32'h0, 5'd12, 5'd0, "R1");
    // R7: reset after data was held
    do_reset();
    for (int k = 0; k < NR; k += 2) step(1'b0, '0, '0, IW'(k + 1), IW'(k), "R7");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule